// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block is one DMA channel that software drives through a small word-addressed register window. Software programs a source and a destination address, an access width and an addressing mode for each side, a unit size in bytes and a unit count. It then writes the start bit, and the engine copies unit size times unit count bytes over a single-outstanding memory request/response master port.

Each beat is one read followed by one write. Between units the engine can leave the port idle for a programmed number of clocks. When a request-select field is nonzero, it also waits for a peripheral request line before each unit. The channel shows busy status and keeps raw and masked interrupt flags for transfer end and for error. Software can abort a running transfer by writing zero to the start bit.

Top module: `dma_chan_top`

## Requirements
- R1: After reset every register reads zero. Registers keep only their defined fields. The unit size at 0x28 is 26 bits, the unit count at 0x2C is 16 bits, and the address high words at 0x18 (source) and 0x1C (destination) are ADDR_W-32 bits. The address low words are at 0x20 (source) and 0x24 (destination).
- R2: Writing 1 to bit 0 of 0x30 while idle starts a transfer. Bit 0 of 0x40 reads 1 while the transfer runs and 0 once it ends. A start written while busy is ignored.
- R3: Each beat is a read at the current source address followed by a write at the current destination address. The write carries the data returned by that read. Both accesses present the size code min(source code, destination code) on mem_size_o. A request is held, unchanged, until its response arrives.
- R4: In the mode registers, 0x10 for the source and 0x14 for the destination, bits 25:24 hold the width as log2 of the byte count. Bit 4 set keeps that side's address fixed. Bit 4 clear advances it by the beat byte count, 1 << mem_size_o, after each access.
- R5: A transfer moves unit size × unit count bytes. A start with a zero unit size or a zero count makes no memory access and raises the end flag.
- R6: The transfer-factor register is at 0x08, with the idle-interval count N in bits 23:16 and the request select in bits 5:0. Between two units the memory request stays low for exactly N+1 cycles. Beats within a unit follow each other with no idle cycle.
- R7: While request select is nonzero, no unit starts, the first one included, until periph_req_i is high.
- R8: Writing 0 to bit 0 of 0x30 while busy stops the transfer. Busy reads 0 from the next cycle, no further access is accepted, and no flag is raised.
- R9: The raw flags are at 0x38, with bit 0 for end and bit 1 for error. Writing 1 to a flag bit clears it. The enables are at 0x34, with the same bit positions. The masked flags at 0x3C equal raw AND enable, and irq_o is the OR of the masked flags.
- R10: A response with mem_rsp_err_i set raises the error flag, clears busy and ends the transfer with no further access.
- R11: A start raises the error flag and makes no memory access when either of these holds: the unit size is not a multiple of both widths, or an address is not aligned to its own side's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| periph_req_i | input | 1 | Peripheral request that paces units |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_size_o | output | 2 | Access size as log2 of bytes |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rsp_valid_i | input | 1 | Response for the pending request |
| mem_rsp_err_i | input | 1 | Response carries an error |
| mem_rdata_i | input | DATA_W | Read response data |
| irq_o | output | 1 | Interrupt, OR of masked flags |

## Verification
A register write is sampled at one edge. The busy change it causes, whether start or abort, is visible right after that edge. A request issued after edge e is accepted on the edge at which the response is present, and the next access starts right after. End and error events reach the raw flags one edge after the engine goes idle. The bench therefore reads flags only after polling busy low, and samples everything at the falling edge. The memory model answers one cycle after each request. A behavioural queue of expected accesses is compared against each accepted request, and idle runs on mem_req_o are measured cycle by cycle against N+1.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RD, ST_WR} eng_state_e;

  localparam logic [7:0] OFS_FACTOR = 8'h08;
  localparam logic [7:0] OFS_SMODE  = 8'h10;
  localparam logic [7:0] OFS_DMODE  = 8'h14;
  localparam logic [7:0] OFS_SHI    = 8'h18;
  localparam logic [7:0] OFS_DHI    = 8'h1C;
  localparam logic [7:0] OFS_SLO    = 8'h20;
  localparam logic [7:0] OFS_DLO    = 8'h24;
  localparam logic [7:0] OFS_USIZE  = 8'h28;
  localparam logic [7:0] OFS_UCNT   = 8'h2C;
  localparam logic [7:0] OFS_CTRL   = 8'h30;
  localparam logic [7:0] OFS_IEN    = 8'h34;
  localparam logic [7:0] OFS_RAW    = 8'h38;
  localparam logic [7:0] OFS_MSK    = 8'h3C;
  localparam logic [7:0] OFS_STAT   = 8'h40;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int USIZE_W = 26,
  parameter int UCNT_W  = 16,
  parameter int GAP_W   = 8,
  parameter int SEL_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               busy_i,
  input  logic               end_evt_i,
  input  logic               err_evt_i,
  output logic               start_o,
  output logic               abort_o,
  output logic [ADDR_W-1:0]  src_base_o,
  output logic [ADDR_W-1:0]  dst_base_o,
  output logic               src_fixed_o,
  output logic               dst_fixed_o,
  output logic [1:0]         src_code_o,
  output logic [1:0]         dst_code_o,
  output logic [USIZE_W-1:0] unit_size_o,
  output logic [UCNT_W-1:0]  unit_cnt_o,
  output logic [GAP_W-1:0]   gap_o,
  output logic [SEL_W-1:0]   req_sel_o,
  output logic               irq_o
);
  localparam int HI_W = ADDR_W - 32;

  logic [HI_W-1:0] src_hi_q, dst_hi_q;
  logic [31:0]     src_lo_q, dst_lo_q;
  logic [1:0]      ien_q, raw_q, set_v, clr_v;

  assign set_v = {err_evt_i, end_evt_i};
  assign clr_v = (reg_we_i && reg_addr_i == OFS_RAW) ? reg_wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_hi_q <= '0; dst_hi_q <= '0; src_lo_q <= '0; dst_lo_q <= '0;
      src_fixed_o <= 1'b0; dst_fixed_o <= 1'b0;
      src_code_o <= '0; dst_code_o <= '0;
      unit_size_o <= '0; unit_cnt_o <= '0; gap_o <= '0; req_sel_o <= '0;
      ien_q <= '0; raw_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_v) | set_v;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          OFS_FACTOR: begin
            gap_o     <= reg_wdata_i[16 +: GAP_W];
            req_sel_o <= reg_wdata_i[SEL_W-1:0];
          end
          OFS_SMODE: begin src_fixed_o <= reg_wdata_i[4]; src_code_o <= reg_wdata_i[25:24]; end
          OFS_DMODE: begin dst_fixed_o <= reg_wdata_i[4]; dst_code_o <= reg_wdata_i[25:24]; end
          OFS_SHI:   src_hi_q <= reg_wdata_i[HI_W-1:0];
          OFS_DHI:   dst_hi_q <= reg_wdata_i[HI_W-1:0];
          OFS_SLO:   src_lo_q <= reg_wdata_i;
          OFS_DLO:   dst_lo_q <= reg_wdata_i;
          OFS_USIZE: unit_size_o <= reg_wdata_i[USIZE_W-1:0];
          OFS_UCNT:  unit_cnt_o <= reg_wdata_i[UCNT_W-1:0];
          OFS_IEN:   ien_q <= reg_wdata_i[1:0];
          default: ;
        endcase
      end
    end
  end

  assign src_base_o = {src_hi_q, src_lo_q};
  assign dst_base_o = {dst_hi_q, dst_lo_q};
  assign start_o = reg_we_i && reg_addr_i == OFS_CTRL && reg_wdata_i[0];
  assign abort_o = reg_we_i && reg_addr_i == OFS_CTRL && !reg_wdata_i[0];
  assign irq_o   = |(raw_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_FACTOR: begin
        reg_rdata_o[16 +: GAP_W]  = gap_o;
        reg_rdata_o[SEL_W-1:0]    = req_sel_o;
      end
      OFS_SMODE: begin reg_rdata_o[25:24] = src_code_o; reg_rdata_o[4] = src_fixed_o; end
      OFS_DMODE: begin reg_rdata_o[25:24] = dst_code_o; reg_rdata_o[4] = dst_fixed_o; end
      OFS_SHI:   reg_rdata_o[HI_W-1:0] = src_hi_q;
      OFS_DHI:   reg_rdata_o[HI_W-1:0] = dst_hi_q;
      OFS_SLO:   reg_rdata_o = src_lo_q;
      OFS_DLO:   reg_rdata_o = dst_lo_q;
      OFS_USIZE: reg_rdata_o[USIZE_W-1:0] = unit_size_o;
      OFS_UCNT:  reg_rdata_o[UCNT_W-1:0] = unit_cnt_o;
      OFS_CTRL:  reg_rdata_o[0] = busy_i;
      OFS_IEN:   reg_rdata_o[1:0] = ien_q;
      OFS_RAW:   reg_rdata_o[1:0] = raw_q;
      OFS_MSK:   reg_rdata_o[1:0] = raw_q & ien_q;
      OFS_STAT:  reg_rdata_o[0] = busy_i;
      default: ;
    endcase
  end

  // R9
  err_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> raw_q[1]);
  // R9
  end_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_evt_i |=> raw_q[0]);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int USIZE_W = 26,
  parameter int UCNT_W  = 16,
  parameter int GAP_W   = 8,
  parameter int SEL_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [ADDR_W-1:0]  src_base_i,
  input  logic [ADDR_W-1:0]  dst_base_i,
  input  logic               src_fixed_i,
  input  logic               dst_fixed_i,
  input  logic [1:0]         src_code_i,
  input  logic [1:0]         dst_code_i,
  input  logic [USIZE_W-1:0] unit_size_i,
  input  logic [UCNT_W-1:0]  unit_cnt_i,
  input  logic [GAP_W-1:0]   gap_i,
  input  logic [SEL_W-1:0]   req_sel_i,
  input  logic               periph_req_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [1:0]         mem_size_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_rsp_valid_i,
  input  logic               mem_rsp_err_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic               end_evt_o,
  output logic               err_evt_o
);
  eng_state_e         state_q;
  logic [ADDR_W-1:0]  cur_src_q, cur_dst_q;
  logic [USIZE_W-1:0] bytes_left_q;
  logic [UCNT_W-1:0]  units_left_q;
  logic [GAP_W-1:0]   gap_cnt_q;
  logic [1:0]         narrow, wide;
  logic [3:0]         beat_bytes, wide_m, src_m, dst_m;
  logic               cfg_bad;

  assign narrow     = (src_code_i < dst_code_i) ? src_code_i : dst_code_i;
  assign wide       = (src_code_i < dst_code_i) ? dst_code_i : src_code_i;
  assign beat_bytes = 4'd1 << narrow;
  assign wide_m     = (4'd1 << wide) - 4'd1;
  assign src_m      = (4'd1 << src_code_i) - 4'd1;
  assign dst_m      = (4'd1 << dst_code_i) - 4'd1;
  assign cfg_bad    = |(unit_size_i[2:0] & wide_m[2:0]) |
                      |(src_base_i[2:0] & src_m[2:0]) |
                      |(dst_base_i[2:0] & dst_m[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_src_q <= '0; cur_dst_q <= '0;
      bytes_left_q <= '0; units_left_q <= '0; gap_cnt_q <= '0;
      mem_wdata_o <= '0; end_evt_o <= 1'b0; err_evt_o <= 1'b0;
    end else begin
      end_evt_o <= 1'b0;
      err_evt_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (cfg_bad) err_evt_o <= 1'b1;
          else if (unit_size_i == '0 || unit_cnt_i == '0) end_evt_o <= 1'b1;
          else begin
            cur_src_q    <= src_base_i;
            cur_dst_q    <= dst_base_i;
            bytes_left_q <= unit_size_i;
            units_left_q <= unit_cnt_i;
            gap_cnt_q    <= '0;
            state_q      <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt_q != '0) gap_cnt_q <= gap_cnt_q - 1'b1;
          else if (req_sel_i == '0 || periph_req_i) state_q <= ST_RD;
        end
        ST_RD: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            err_evt_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            mem_wdata_o <= mem_rdata_i;
            if (!src_fixed_i) cur_src_q <= cur_src_q + ADDR_W'(beat_bytes);
            state_q <= ST_WR;
          end
        end
        ST_WR: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            err_evt_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            if (!dst_fixed_i) cur_dst_q <= cur_dst_q + ADDR_W'(beat_bytes);
            if (bytes_left_q == USIZE_W'(beat_bytes)) begin
              if (units_left_q == UCNT_W'(1)) begin
                end_evt_o <= 1'b1;
                state_q   <= ST_IDLE;
              end else begin
                units_left_q <= units_left_q - 1'b1;
                bytes_left_q <= unit_size_i;
                gap_cnt_q    <= gap_i;
                state_q      <= ST_GAP;
              end
            end else begin
              bytes_left_q <= bytes_left_q - USIZE_W'(beat_bytes);
              state_q      <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (abort_i && state_q != ST_IDLE) begin
        state_q   <= ST_IDLE;
        end_evt_o <= 1'b0;
        err_evt_o <= 1'b0;
      end
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign mem_req_o  = state_q == ST_RD || state_q == ST_WR;
  assign mem_we_o   = state_q == ST_WR;
  assign mem_addr_o = (state_q == ST_WR) ? cur_dst_q : cur_src_q;
  assign mem_size_o = narrow;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_valid_i && !abort_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && busy_o |=> !busy_o && !mem_req_o);
  // R10
  rsp_err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rsp_valid_i && mem_rsp_err_i |=> !busy_o && !mem_req_o);
  // R11
  cfg_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && cfg_bad |=> !busy_o && err_evt_o);
  // R4
  src_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && src_fixed_i |-> mem_addr_o == src_base_i);
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top #(
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int USIZE_W = 26,
  parameter int UCNT_W  = 16,
  parameter int GAP_W   = 8,
  parameter int SEL_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              periph_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  logic               busy, end_evt, err_evt, start, abort;
  logic               src_fixed, dst_fixed;
  logic [1:0]         src_code, dst_code;
  logic [ADDR_W-1:0]  src_base, dst_base;
  logic [USIZE_W-1:0] unit_size;
  logic [UCNT_W-1:0]  unit_cnt;
  logic [GAP_W-1:0]   gap;
  logic [SEL_W-1:0]   req_sel;

  dma_chan_regs #(.ADDR_W(ADDR_W), .USIZE_W(USIZE_W), .UCNT_W(UCNT_W),
                  .GAP_W(GAP_W), .SEL_W(SEL_W)) regs_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .end_evt_i(end_evt), .err_evt_i(err_evt),
    .start_o(start), .abort_o(abort),
    .src_base_o(src_base), .dst_base_o(dst_base),
    .src_fixed_o(src_fixed), .dst_fixed_o(dst_fixed),
    .src_code_o(src_code), .dst_code_o(dst_code),
    .unit_size_o(unit_size), .unit_cnt_o(unit_cnt),
    .gap_o(gap), .req_sel_o(req_sel), .irq_o);

  dma_chan_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USIZE_W(USIZE_W),
                    .UCNT_W(UCNT_W), .GAP_W(GAP_W), .SEL_W(SEL_W)) eng_i (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort),
    .src_base_i(src_base), .dst_base_i(dst_base),
    .src_fixed_i(src_fixed), .dst_fixed_i(dst_fixed),
    .src_code_i(src_code), .dst_code_i(dst_code),
    .unit_size_i(unit_size), .unit_cnt_i(unit_cnt),
    .gap_i(gap), .req_sel_i(req_sel), .periph_req_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_size_o, .mem_wdata_o,
    .mem_rsp_valid_i, .mem_rsp_err_i, .mem_rdata_i,
    .busy_o(busy), .end_evt_o(end_evt), .err_evt_o(err_evt));
endmodule

// File: tb/dma_chan_top_tb_top.sv
module dma_chan_top_tb_top;
  localparam int AW = 40;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = 8'h00;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          periph_req = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata;
  logic          rsp_valid = 1'b0;
  logic          rsp_err = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic          irq;

  int errors = 0;
  int checks = 0;
  int acc_cnt = 0;
  int idle_run = 0;
  bit seen_req = 0;
  bit abort_mode = 0;
  logic [AW-1:0] err_addr = '1;
  logic [AW-1:0] exp_addr_q[$];
  bit            exp_we_q[$];
  logic [1:0]    exp_size_q[$];
  logic [DW-1:0] exp_data_q[$];
  int            gaps_q[$];
  logic [31:0]   rv;

  always #10 clk = ~clk;

  dma_chan_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .periph_req_i(periph_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_err_i(rsp_err), .mem_rdata_i(rdata), .irq_o(irq));

  function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
    return {a[31:0] ^ 32'hA5A5_0000, ~a[31:0]};
  endfunction

  // memory model: answers one cycle after a request
  always @(posedge clk) begin
    rsp_valid <= mem_req && !rsp_valid;
    rsp_err   <= mem_req && !rsp_valid && (mem_addr == err_addr);
    rdata     <= data_of(mem_addr);
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transaction monitor and idle-run measurement
  always @(negedge clk) begin
    if (rst_n && mem_req && rsp_valid) begin
      acc_cnt++;
      if (exp_addr_q.size() == 0) begin
        if (!abort_mode) chk(0, "R3 unexpected access", mem_addr, 0);
      end else begin
        chk(mem_addr == exp_addr_q[0], "R3/R4 address", mem_addr, exp_addr_q[0]);
        chk(mem_we == exp_we_q[0], "R3 direction", mem_we, exp_we_q[0]);
        chk(mem_size == exp_size_q[0], "R3 size code", mem_size, exp_size_q[0]);
        if (exp_we_q[0]) chk(mem_wdata == exp_data_q[0], "R3 write data", mem_wdata, exp_data_q[0]);
        void'(exp_addr_q.pop_front()); void'(exp_we_q.pop_front());
        void'(exp_size_q.pop_front()); void'(exp_data_q.pop_front());
      end
    end
    if (!mem_req) idle_run++;
    else begin
      if (seen_req && idle_run > 0) gaps_q.push_back(idle_run);
      seen_req = 1;
      idle_run = 0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h40, s);
      if (!s[0]) return;
    end
    chk(0, "R2 busy never cleared", 1, 0);
  endtask

  task automatic push_xfer(logic [AW-1:0] s, logic [1:0] sc, bit sf,
                           logic [AW-1:0] d, logic [1:0] dc, bit df,
                           int usize, int ucnt, int limit);
    logic [1:0] n;
    int bb, pushed;
    logic [AW-1:0] ca, cd;
    n = (sc < dc) ? sc : dc;
    bb = 1 << n;
    ca = s; cd = d; pushed = 0;
    for (int u = 0; u < ucnt; u++)
      for (int b = 0; b < usize / bb; b++) begin
        if (pushed >= limit) return;
        exp_addr_q.push_back(ca); exp_we_q.push_back(0);
        exp_size_q.push_back(n); exp_data_q.push_back('0);
        pushed++;
        if (pushed >= limit) return;
        exp_addr_q.push_back(cd); exp_we_q.push_back(1);
        exp_size_q.push_back(n); exp_data_q.push_back(data_of(ca));
        pushed++;
        if (!sf) ca = ca + AW'(bb);
        if (!df) cd = cd + AW'(bb);
      end
  endtask

  task automatic setup(logic [AW-1:0] s, logic [1:0] sc, bit sf,
                       logic [AW-1:0] d, logic [1:0] dc, bit df,
                       int usize, int ucnt, int gap, int sel);
    wr(8'h20, s[31:0]); wr(8'h18, 32'(s[AW-1:32]));
    wr(8'h24, d[31:0]); wr(8'h1C, 32'(d[AW-1:32]));
    wr(8'h10, {6'd0, sc, 19'd0, sf, 4'd0});
    wr(8'h14, {6'd0, dc, 19'd0, df, 4'd0});
    wr(8'h28, 32'(usize)); wr(8'h2C, 32'(ucnt));
    wr(8'h08, {8'd0, 8'(gap), 10'd0, 6'(sel)});
  endtask

  initial begin
    int a0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h38, rv); chk(rv == 0, "R1 raw flags after reset", rv, 0);
    rd(8'h40, rv); chk(rv == 0, "R1 status after reset", rv, 0);
    rd(8'h28, rv); chk(rv == 0, "R1 unit size after reset", rv, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);

    // R1 field widths
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, rv); chk(rv == 32'h03FF_FFFF, "R1 unit size width", rv, 32'h03FF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, rv); chk(rv == 32'h0000_FFFF, "R1 unit count width", rv, 32'hFFFF);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, rv); chk(rv == 32'h0000_00FF, "R1 high address width", rv, 32'hFF);

    // R2 R3 R4 R5 R6 R9: incrementing 8-byte, 2 units of 32 bytes, gap 3
    wr(8'h34, 32'h1);
    setup(40'h00_0000_1000, 2'd3, 0, 40'h00_0000_2000, 2'd3, 0, 32, 2, 3, 0);
    push_xfer(40'h1000, 2'd3, 0, 40'h2000, 2'd3, 0, 32, 2, 1000);
    gaps_q.delete(); seen_req = 0;
    wr(8'h30, 32'h1);
    rd(8'h40, rv); chk(rv[0] == 1, "R2 busy while running", rv, 1);
    wr(8'h30, 32'h1); // R2 start while busy is ignored
    wait_idle();
    chk(exp_addr_q.size() == 0, "R5 all accesses of unit size x count", exp_addr_q.size(), 0);
    chk(gaps_q.size() == 1, "R6 one inter-unit gap", gaps_q.size(), 1);
    if (gaps_q.size() > 0) chk(gaps_q[0] == 4, "R6 gap length N+1", gaps_q[0], 4);
    rd(8'h38, rv); chk(rv == 1, "R9 end flag raw", rv, 1);
    rd(8'h3C, rv); chk(rv == 1, "R9 end flag masked", rv, 1);
    chk(irq == 1, "R9 irq on end", irq, 1);
    wr(8'h38, 32'h1); rd(8'h38, rv); chk(rv == 0, "R9 write one clears", rv, 0);
    chk(irq == 0, "R9 irq cleared", irq, 0);

    // R4 fixed source, mixed width: 4-byte beats
    setup(40'h00_0000_3004, 2'd2, 1, 40'h00_0000_4000, 2'd3, 0, 16, 1, 0, 0);
    push_xfer(40'h3004, 2'd2, 1, 40'h4000, 2'd3, 0, 16, 1, 1000);
    wr(8'h30, 32'h1); wait_idle();
    chk(exp_addr_q.size() == 0, "R4 fixed source transfer complete", exp_addr_q.size(), 0);
    wr(8'h38, 32'h3);

    // R4 fixed destination, byte beats, gap 0
    setup(40'h00_0000_5001, 2'd0, 0, 40'h00_0000_6002, 2'd1, 1, 4, 2, 0, 0);
    push_xfer(40'h5001, 2'd0, 0, 40'h6002, 2'd1, 1, 4, 2, 1000);
    gaps_q.delete(); seen_req = 0;
    wr(8'h30, 32'h1); wait_idle();
    chk(exp_addr_q.size() == 0, "R4 fixed destination transfer complete", exp_addr_q.size(), 0);
    if (gaps_q.size() > 0) chk(gaps_q[0] == 1, "R6 zero interval gap", gaps_q[0], 1);
    else chk(0, "R6 zero interval gap missing", 0, 1);
    wr(8'h38, 32'h3);

    // R5 zero count
    wr(8'h2C, 32'h0);
    a0 = acc_cnt;
    wr(8'h30, 32'h1); repeat (4) @(negedge clk);
    chk(acc_cnt == a0, "R5 zero count no access", acc_cnt, a0);
    rd(8'h38, rv); chk(rv == 1, "R5 zero count end flag", rv, 1);
    wr(8'h38, 32'h3);

    // R11 unaligned size, error disabled then enabled
    wr(8'h34, 32'h0);
    setup(40'h00_0000_1000, 2'd3, 0, 40'h00_0000_2000, 2'd3, 0, 12, 1, 0, 0);
    a0 = acc_cnt;
    wr(8'h30, 32'h1); repeat (4) @(negedge clk);
    chk(acc_cnt == a0, "R11 bad size no access", acc_cnt, a0);
    rd(8'h38, rv); chk(rv == 2, "R11 bad size error flag", rv, 2);
    rd(8'h3C, rv); chk(rv == 0, "R9 masked flag with enable off", rv, 0);
    chk(irq == 0, "R9 no irq when disabled", irq, 0);
    wr(8'h34, 32'h2);
    rd(8'h3C, rv); chk(rv == 2, "R9 masked error flag", rv, 2);
    chk(irq == 1, "R9 irq on error", irq, 1);
    wr(8'h38, 32'h2);
    // R11 misaligned source address
    setup(40'h00_0000_1003, 2'd2, 0, 40'h00_0000_2000, 2'd2, 0, 8, 1, 0, 0);
    wr(8'h30, 32'h1); repeat (4) @(negedge clk);
    chk(acc_cnt == a0, "R11 misaligned address no access", acc_cnt, a0);
    rd(8'h38, rv); chk(rv == 2, "R11 misaligned address error flag", rv, 2);
    wr(8'h38, 32'h3);

    // R10 error response on third read
    err_addr = 40'h7010;
    setup(40'h00_0000_7000, 2'd3, 0, 40'h00_0000_8000, 2'd3, 0, 16, 2, 0, 0);
    push_xfer(40'h7000, 2'd3, 0, 40'h8000, 2'd3, 0, 16, 2, 5);
    wr(8'h30, 32'h1); wait_idle();
    repeat (5) @(negedge clk);
    chk(exp_addr_q.size() == 0, "R10 accesses up to error", exp_addr_q.size(), 0);
    rd(8'h38, rv); chk(rv == 2, "R10 error flag", rv, 2);
    rd(8'h40, rv); chk(rv == 0, "R10 busy cleared", rv, 0);
    err_addr = '1;
    wr(8'h38, 32'h3);

    // R7 pacing by peripheral request
    setup(40'h00_0000_9000, 2'd3, 0, 40'h00_0000_A000, 2'd3, 0, 8, 2, 0, 1);
    push_xfer(40'h9000, 2'd3, 0, 40'hA000, 2'd3, 0, 8, 2, 1000);
    a0 = acc_cnt;
    wr(8'h30, 32'h1); repeat (20) @(negedge clk);
    chk(acc_cnt == a0, "R7 held without peripheral request", acc_cnt, a0);
    rd(8'h40, rv); chk(rv[0] == 1, "R7 busy while waiting", rv, 1);
    periph_req = 1'b1;
    wait_idle();
    periph_req = 1'b0;
    chk(exp_addr_q.size() == 0, "R7 paced transfer complete", exp_addr_q.size(), 0);
    wr(8'h38, 32'h3);

    // R8 abort
    setup(40'h00_0001_0000, 2'd3, 0, 40'h00_0002_0000, 2'd3, 0, 8, 100, 0, 0);
    abort_mode = 1;
    wr(8'h30, 32'h1); repeat (10) @(negedge clk);
    wr(8'h30, 32'h0);
    rd(8'h40, rv); chk(rv[0] == 0, "R8 busy falls after abort", rv, 0);
    a0 = acc_cnt;
    repeat (20) @(negedge clk);
    chk(acc_cnt == a0, "R8 no access after abort", acc_cnt, a0);
    chk(mem_req == 0, "R8 request low after abort", mem_req, 0);
    rd(8'h38, rv); chk(rv == 0, "R8 no flag on abort", rv, 0);
    abort_mode = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule